// File: doc/BRIEF.md
# Audio Bit-Clock Generator

This block produces the serial bit clock of an audio port from the master clock that also runs the port's own logic. A linear divider sets the rate. The divider can also stop the clock or pass the master clock through unchanged. A gate control stops the clock without cutting any pulse short. When the port is the bit-clock slave, or when an external source is selected, the clock comes from a pad input instead. That input is brought into the master-clock domain through a synchronizer.

Downstream serializer and deserializer logic does not use the bit clock as a clock. It uses two strobes in the master-clock domain, one for each rising edge and one for each falling edge of the active bit clock. Separate inversion controls are provided. One flips the clock driven to the pad, and applies only as master. The other flips the clock taken from the pad, and applies only as slave.

The divide value, the source selection and the mode are expected to stay static while the port is enabled.

Top module: `bclk_gen`

## Requirements
- R1: The divide value is captured from `div_val` only on rising clock edges where `port_en` is low. Any change to `div_val` while `port_en` is high leaves the running bit clock unchanged.
- R2: With a captured divide value of 0, in master mode with the internal source, no bit clock is produced. `bclk_pad` stays at the value of `inv_out` and both strobes stay low.
- R3: With a captured divide value of 1, in master mode with the internal source, `bclk_pad` follows the master clock. Both strobes are high in every cycle. The pass-through is switched on and off only at falling master-clock edges.
- R4: With a captured divide value n from 2 to 511, the generated clock has a period of n master cycles. Each period has a low phase of n - floor(n/2) cycles followed by a high phase of floor(n/2) cycles. The first rising clock edge that samples `port_en` high moves the clock to position 1 of the low phase, and the clock rises on the edge that reaches position n - floor(n/2).
- R5: For a divided clock, `rise_stb` is high exactly in the first cycle the clock is high, and `fall_stb` is high exactly in the first cycle it is low again. The two strobes are never high together outside pass-through.
- R6: `gate_off` takes effect only while the bit clock is low. A high phase that has already started completes at full length, after which the clock stays low. On release, the divided clock runs a full low phase before rising. On the external path, gating stops both strobes and the forwarded clock.
- R7: In master mode, `inv_out` flips `bclk_pad`. In slave mode (`is_master` low), `bclk_pad` is held at 0 whatever the value of `inv_out`.
- R8: In slave mode, the bit clock is `ext_bclk` after a two-flop synchronizer, flipped when `inv_in` is 1. An edge driven on `ext_bclk` shows on the strobes in the cycle after the second rising clock edge, for one cycle. `inv_in` has no effect in master mode.
- R9: In master mode with `src_ext` high, the synchronized `ext_bclk` (not inverted by `inv_in`) replaces the divided clock on `bclk_pad`, with `inv_out` applied. Its timing is the same as in R8.
- R10: While reset is held and directly after it, both strobes are low. The captured divide value is 0, so in master mode `bclk_pad` equals `inv_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; all logic runs on it |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Port enable; the divide value is captured while low |
| div_val | input | 9 | Linear divide value (0 stops, 1 passes through) |
| gate_off | input | 1 | Stops the bit clock at its next low phase |
| inv_out | input | 1 | Inverts the pad clock in master mode |
| inv_in | input | 1 | Inverts the pad input in slave mode |
| src_ext | input | 1 | Selects the external pad clock in master mode |
| is_master | input | 1 | 1: this side drives the bit clock; 0: slave |
| ext_bclk | input | 1 | Bit clock from the pad |
| bclk_pad | output | 1 | Bit clock to the pad |
| rise_stb | output | 1 | One-cycle strobe on each bit-clock rising edge |
| fall_stb | output | 1 | One-cycle strobe on each bit-clock falling edge |

## Verification
For a divided clock, the pad level and the strobes change at the rising edge that samples the enable, gate or counter condition. The check for that edge is due in the sample that immediately follows it. Pass-through switching takes effect at the falling edge that follows the input change, so it shows in the next sample. The external path needs two rising edges before its result appears. All inputs are driven and all outputs are sampled 3 ns after a rising edge, before the falling edge. This lets every expected value be placed in a fixed cycle counted from the stimulus, and the pass-through check adds one extra sample taken while the master clock is low.

// File: rtl/bclk_pkg.sv
// Shared types for the bit-clock generator.
// Assumes: nothing beyond IEEE 1800-2017.
package bclk_pkg;

    // Active source of the bit clock, derived from mode and divide value.
    typedef enum logic [1:0] {
        SRC_IDLE = 2'd0,
        SRC_PASS = 2'd1,
        SRC_DIV  = 2'd2,
        SRC_EXT  = 2'd3
    } bclk_src_e;

    // Default synchronizer depth for the external pad clock.
    localparam int unsigned BCLK_SYNC_DEPTH = 2;

endpackage

// File: rtl/bclk_div_core.sv
// Linear divider: turns the master clock into a bit clock of period div_n.
// The low phase comes first (div_n - div_n/2 cycles), then the high phase.
// Gating is honoured only while the output is low, so no pulse is ever cut.
// Assumes: div_n >= 2 and stable whenever run_en is high.
module bclk_div_core #(
    parameter int unsigned DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             gate_off,
    input  logic [DIV_W-1:0] div_n,
    output logic             bclk_q,
    output logic             rise_q,
    output logic             fall_q
);
    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] cnt_n;
    logic [DIV_W-1:0] hi_len;
    logic [DIV_W-1:0] lo_len;
    logic [DIV_W-1:0] last_pos;
    logic             hold;
    logic             bclk_n;

    // Next position within the period, and the level that position implies.
    always_comb begin
        hi_len   = div_n >> 1;
        lo_len   = div_n - hi_len;
        last_pos = div_n - ONE;
        hold     = !run_en || (gate_off && !bclk_q);
        if (hold) begin
            cnt_n  = '0;
            bclk_n = 1'b0;
        end else begin
            cnt_n  = (cnt_q == last_pos) ? '0 : cnt_q + ONE;
            bclk_n = (cnt_n >= lo_len);
        end
    end

    // Position counter, clock level and edge strobes advance together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bclk_q <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_n;
            bclk_q <= bclk_n;
            rise_q <= bclk_n && !bclk_q;
            fall_q <= !bclk_n && bclk_q;
        end
    end
endmodule

// File: rtl/bclk_pass_gate.sv
// Divide-by-one path: forwards the master clock through a gate whose
// enable changes only on the falling edge, while the clock is low.
// Assumes: pass_en settles before the falling edge of each cycle.
module bclk_pass_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic pass_en,
    output logic bclk,
    output logic strobe
);
    logic en_q;

    // Gate enable captured while the master clock is low.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= pass_en;
        end
    end

    assign bclk   = clk & en_q;
    assign strobe = en_q;
endmodule

// File: rtl/bclk_ext_path.sv
// External bit-clock path: synchronizes the pad clock, optionally inverts
// it, gates it while it is low, and detects its edges.
// Assumes: the pad clock is slower than half the master clock.
module bclk_ext_path #(
    parameter int unsigned SYNC_N = bclk_pkg::BCLK_SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic gate_off,
    input  logic invert,
    input  logic ext_in,
    output logic bclk,
    output logic rise,
    output logic fall
);
    logic [SYNC_N-1:0] sync_q;
    logic              cur;
    logic              run_q;
    logic              prev_q;

    // Synchronizer chain for the asynchronous pad input.
    generate
        if (SYNC_N == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= ext_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_N-2:0], ext_in};
            end
        end
    endgenerate

    assign cur  = sync_q[SYNC_N-1] ^ invert;
    assign bclk = cur & run_q;

    // Run flag moves only while the synchronized clock is low.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            run_q <= 1'b0;
        end else if (!cur) begin
            run_q <= !gate_off;
        end
    end

    // Previous level of the gated clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= bclk;
    end

    assign rise = bclk & !prev_q;
    assign fall = !bclk & prev_q;
endmodule

// File: rtl/bclk_gen.sv
// Bit-clock generator top: captures the divide value while the port is off,
// selects among idle, pass-through, divided and external sources, and
// applies output inversion in master mode.
// Assumes: div_val, src_ext and is_master are static while port_en is high.
module bclk_gen
    import bclk_pkg::*;
#(
    parameter int unsigned DIV_W  = 9,
    parameter int unsigned SYNC_N = BCLK_SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_en,
    input  logic [DIV_W-1:0] div_val,
    input  logic             gate_off,
    input  logic             inv_out,
    input  logic             inv_in,
    input  logic             src_ext,
    input  logic             is_master,
    input  logic             ext_bclk,
    output logic             bclk_pad,
    output logic             rise_stb,
    output logic             fall_stb
);
    localparam logic [DIV_W-1:0] DIV_ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    logic [DIV_W-1:0] div_lat;
    bclk_src_e        mode;
    logic             div_run;
    logic             div_bclk, div_rise, div_fall;
    logic             pass_en, pass_clk, pass_stb;
    logic             ext_run, ext_clk, ext_rise, ext_fall;
    logic             gen_clk, gen_rise, gen_fall;

    // Divide value is captured only while the port is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_lat <= '0;
        end else if (!port_en) begin
            div_lat <= div_val;
        end
    end

    // Decode the active source from mode bits and divide value.
    always_comb begin
        if (src_ext || !is_master)   mode = SRC_EXT;
        else if (div_lat == '0)      mode = SRC_IDLE;
        else if (div_lat == DIV_ONE) mode = SRC_PASS;
        else                         mode = SRC_DIV;
    end

    assign div_run = port_en && (mode == SRC_DIV);
    assign pass_en = port_en && (mode == SRC_PASS) && !gate_off;
    assign ext_run = port_en && (mode == SRC_EXT);

    bclk_div_core #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (div_run),
        .gate_off (gate_off),
        .div_n    (div_lat),
        .bclk_q   (div_bclk),
        .rise_q   (div_rise),
        .fall_q   (div_fall)
    );

    bclk_pass_gate u_pass (
        .clk     (clk),
        .rst_n   (rst_n),
        .pass_en (pass_en),
        .bclk    (pass_clk),
        .strobe  (pass_stb)
    );

    bclk_ext_path #(.SYNC_N(SYNC_N)) u_ext (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (ext_run),
        .gate_off (gate_off),
        .invert   (inv_in && !is_master),
        .ext_in   (ext_bclk),
        .bclk     (ext_clk),
        .rise     (ext_rise),
        .fall     (ext_fall)
    );

    // Route the active source's clock and strobes.
    always_comb begin
        gen_clk  = 1'b0;
        gen_rise = 1'b0;
        gen_fall = 1'b0;
        unique case (mode)
            SRC_IDLE: ;
            SRC_PASS: begin
                gen_clk  = pass_clk;
                gen_rise = pass_stb;
                gen_fall = pass_stb;
            end
            SRC_DIV: begin
                gen_clk  = div_bclk;
                gen_rise = div_rise;
                gen_fall = div_fall;
            end
            SRC_EXT: begin
                gen_clk  = ext_clk;
                gen_rise = ext_rise;
                gen_fall = ext_fall;
            end
        endcase
    end

    assign bclk_pad = is_master & (gen_clk ^ inv_out);
    assign rise_stb = gen_rise;
    assign fall_stb = gen_fall;
endmodule

// File: rtl/bclk_gen_chk.sv
// Property checker for bclk_gen, attached by bind.
// Assumes: configuration inputs are static while the port is enabled.
module bclk_gen_chk
    import bclk_pkg::*;
#(
    parameter int unsigned DIV_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             port_en,
    input logic             gate_off,
    input bclk_src_e        mode,
    input logic [DIV_W-1:0] div_lat,
    input logic             gen_bclk,
    input logic             gen_run,
    input logic             rise_stb,
    input logic             fall_stb,
    input logic             ext_rise
);
    logic [DIV_W-1:0] hi_run;
    logic [DIV_W:0]   lo_run;
    logic [DIV_W-1:0] exp_hi;
    logic [DIV_W:0]   exp_lo;

    assign exp_hi = div_lat >> 1;
    assign exp_lo = {1'b0, div_lat} - {1'b0, exp_hi};

    // Lengths of the current high and low runs of the divided clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= gen_bclk ? hi_run + 1'b1 : '0;
            lo_run <= gen_bclk ? '0 : ((&lo_run) ? lo_run : lo_run + 1'b1);
        end
    end

    assert_div_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        port_en && $past(port_en) |-> $stable(div_lat));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        port_en && mode == SRC_IDLE |-> !rise_stb && !fall_stb);

    assert_pass_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        port_en && mode == SRC_PASS && !gate_off &&
        $past(port_en && mode == SRC_PASS && !gate_off) |-> rise_stb && fall_stb);

    assert_high_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gen_run) && $past(gen_bclk) && !gen_bclk |-> hi_run == exp_hi);

    assert_low_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gen_run) && !$past(gen_bclk) && gen_bclk |-> lo_run >= exp_lo);

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mode != SRC_PASS |-> !(rise_stb && fall_stb));

    assert_gate_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gen_run) && $past(gate_off) && !$past(gen_bclk) |-> !gen_bclk);

    assert_ext_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rise |=> !ext_rise);
endmodule

bind bclk_gen bclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_en  (port_en),
    .gate_off (gate_off),
    .mode     (mode),
    .div_lat  (div_lat),
    .gen_bclk (div_bclk),
    .gen_run  (div_run),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .ext_rise (ext_rise)
);

// File: tb/tb_bclk_gen.sv
// Self-checking bench: sweeps divide values and walks every source mode.
module tb_bclk_gen;
    logic       clk = 1'b0;
    logic       rst_n, port_en, gate_off, inv_out, inv_in, src_ext, is_master, ext_bclk;
    logic [8:0] div_val;
    logic       bclk_pad, rise_stb, fall_stb;
    int         n_chk = 0;
    int         n_bad = 0;

    always #4 clk = ~clk;

    bclk_gen dut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .div_val(div_val),
        .gate_off(gate_off), .inv_out(inv_out), .inv_in(inv_in),
        .src_ext(src_ext), .is_master(is_master), .ext_bclk(ext_bclk),
        .bclk_pad(bclk_pad), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #3;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Outputs against the three expected values.
    task automatic expect_out(input string tag, input bit pad, input bit r, input bit f);
        chk(bclk_pad == pad, {tag, " pad"}, int'(bclk_pad), int'(pad));
        chk(rise_stb == r, {tag, " rise"}, int'(rise_stb), int'(r));
        chk(fall_stb == f, {tag, " fall"}, int'(fall_stb), int'(f));
    endtask

    // R1/R4/R5/R7: run divide value n and compare each cycle arithmetically.
    task automatic run_div(input int n, input bit inv, input int cycles);
        int lo;
        bit cur, prv;
        lo = n - n / 2;
        port_en = 1'b0; inv_out = inv; div_val = 9'(n);
        cyc(); cyc();
        port_en = 1'b1;
        div_val = 9'((n + 3) % 512);   // R1: must be ignored while enabled
        for (int k = 0; k < cycles; k++) begin
            cyc();
            cur = ((k + 1) % n) >= lo;
            prv = (k == 0) ? 1'b0 : ((k % n) >= lo);
            expect_out("R1 R4 R5 R7 divide", cur ^ inv, cur && !prv, !cur && prv);
        end
        port_en = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; port_en = 1'b0; div_val = '0; gate_off = 1'b0; inv_out = 1'b0;
        inv_in = 1'b0; src_ext = 1'b0; is_master = 1'b1; ext_bclk = 1'b0;
        repeat (3) cyc();
        expect_out("R10 in reset", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        cyc();
        expect_out("R10 after reset", 1'b0, 1'b0, 1'b0);

        // R2: divide value zero, both polarities.
        port_en = 1'b1;
        for (int k = 0; k < 8; k++) begin
            cyc();
            expect_out("R2 zero", 1'b0, 1'b0, 1'b0);
        end
        inv_out = 1'b1;
        cyc();
        for (int k = 0; k < 4; k++) begin
            cyc();
            expect_out("R2 R7 zero inverted", 1'b1, 1'b0, 1'b0);
        end
        port_en = 1'b0; inv_out = 1'b0;

        // R4/R5: sweep of divide values, some inverted.
        for (int n = 2; n <= 24; n++) run_div(n, (n % 5) == 0, 3 * n + 2);
        run_div(255, 1'b0, 2 * 255 + 2);
        run_div(511, 1'b1, 2 * 511 + 2);

        // R3: pass-through, then gated off (R6).
        port_en = 1'b0; div_val = 9'd1; inv_out = 1'b0;
        cyc();
        port_en = 1'b1;
        for (int k = 0; k < 6; k++) begin
            cyc();
            expect_out("R3 pass high", 1'b1, 1'b1, 1'b1);
            #2;
            chk(bclk_pad == 1'b0, "R3 pass low pad", int'(bclk_pad), 0);
        end
        cyc();
        gate_off = 1'b1;
        cyc();
        expect_out("R6 R3 pass gated", 1'b0, 1'b0, 1'b0);
        gate_off = 1'b0; port_en = 1'b0;

        // R6: divide by 6 (low 3, high 3) with gating in both phases.
        div_val = 9'd6;
        cyc(); cyc();
        port_en = 1'b1;
        cyc(); cyc(); cyc();
        expect_out("R6 first rise", 1'b1, 1'b1, 1'b0);
        cyc();
        gate_off = 1'b1;                // asserted during the high phase
        cyc();
        expect_out("R6 high kept", 1'b1, 1'b0, 1'b0);
        cyc();
        expect_out("R6 full high then fall", 1'b0, 1'b0, 1'b1);
        for (int k = 0; k < 10; k++) begin
            cyc();
            expect_out("R6 gated low", 1'b0, 1'b0, 1'b0);
        end
        gate_off = 1'b0;
        cyc();
        gate_off = 1'b1;                // asserted during the low phase
        for (int k = 0; k < 5; k++) begin
            cyc();
            expect_out("R6 gated in low", 1'b0, 1'b0, 1'b0);
        end
        gate_off = 1'b0;
        cyc();
        expect_out("R6 release low 1", 1'b0, 1'b0, 1'b0);
        cyc();
        expect_out("R6 release low 2", 1'b0, 1'b0, 1'b0);
        cyc();
        expect_out("R6 release rise", 1'b1, 1'b1, 1'b0);
        port_en = 1'b0;

        // R8/R7: slave mode, pad clock synchronized, pad output held low.
        is_master = 1'b0; inv_out = 1'b1;
        cyc();
        port_en = 1'b1;
        cyc(); cyc();
        ext_bclk = 1'b1;
        cyc();
        expect_out("R8 sync stage 1", 1'b0, 1'b0, 1'b0);
        cyc();
        expect_out("R8 R7 slave rise", 1'b0, 1'b1, 1'b0);
        cyc();
        expect_out("R8 rise single", 1'b0, 1'b0, 1'b0);
        ext_bclk = 1'b0;
        cyc(); cyc();
        expect_out("R8 slave fall", 1'b0, 1'b0, 1'b1);
        port_en = 1'b0;

        // R8: input inversion in slave mode.
        inv_in = 1'b1;
        cyc();
        port_en = 1'b1;
        cyc(); cyc();
        expect_out("R8 inverted idle", 1'b0, 1'b0, 1'b0);
        ext_bclk = 1'b1;
        cyc(); cyc();
        expect_out("R8 inverted no edge", 1'b0, 1'b0, 1'b0);
        cyc();
        ext_bclk = 1'b0;
        cyc(); cyc();
        expect_out("R8 inverted rise", 1'b0, 1'b1, 1'b0);
        port_en = 1'b0; ext_bclk = 1'b0;

        // R6: gating on the external path.
        inv_in = 1'b0;
        cyc();
        port_en = 1'b1;
        cyc(); cyc();
        gate_off = 1'b1;
        cyc();
        ext_bclk = 1'b1;
        for (int k = 0; k < 4; k++) begin
            cyc();
            expect_out("R6 external gated", 1'b0, 1'b0, 1'b0);
        end
        gate_off = 1'b0; port_en = 1'b0; ext_bclk = 1'b0;

        // R9/R8: master mode forwarding the pad clock; inv_in ignored.
        is_master = 1'b1; src_ext = 1'b1; inv_out = 1'b1; inv_in = 1'b1;
        cyc();
        port_en = 1'b1;
        cyc(); cyc();
        expect_out("R9 forward idle", 1'b1, 1'b0, 1'b0);
        ext_bclk = 1'b1;
        cyc();
        expect_out("R9 forward stage 1", 1'b1, 1'b0, 1'b0);
        cyc();
        expect_out("R9 R8 forward rise", 1'b0, 1'b1, 1'b0);
        port_en = 1'b0;

        finish_run();
    end
endmodule